// File: doc/BRIEF.md
# Banked Interrupt Controller Register File

This block is the register file of a level-sensitive interrupt controller whose lines are grouped into banks of 32. It samples the raw interrupt lines every clock, keeps a pending vector, a sticky software-interrupt vector and a mask per bank, and holds a priority and a route (normal or fast) for every line. A separate arbiter, outside this block, reads the exported pending, mask, route and priority vectors. It returns the winning line codes, and it re-arms when it receives the strobes produced here.

Software reaches the block through a single-cycle write port and a combinational read port on byte addresses. The low two address bits must be zero. Masks change either by a full write or through atomic set and clear aliases, so no read-modify-write is needed. Two filtered views give the unmasked pending lines for each route directly. A global control word can silence the controller, and a configuration bit puts every piece of state back to its reset value.

Top module: `intc_regfile`

## Requirements
- R1: After reset every mask bit is 1 and inputs, pending, software, priority, route, global mask, autoidle and idle bits are 0. Address 0x000 reads 0x21 and address 0x014 reads 1 at all times.
- R2: A line going from 0 to 1 sets its input bit and its pending bit. When any line of a bank goes from 1 to 0, that bank's pending becomes its current inputs OR its software bits. Line events take effect at the clock edge that samples them.
- R3: Bank b's registers start at 0x080 + 0x20*b. A write to +0x04 loads the mask, a write to +0x08 clears the mask bits that are 1 in the data, and a write to +0x0C sets them. Reads of +0x08, +0x0C and +0x14 return 0.
- R4: A write to +0x10 ORs the data into the software register and ORs the new software value into pending. A write to +0x14 clears the software bits that are 1 in the data and then sets pending to software AND inputs. +0x10 reads the software register and +0x00 reads the sampled inputs.
- R5: +0x18 reads pending AND NOT mask AND NOT route. +0x1C reads pending AND NOT mask AND route.
- R6: A write to 0x048 sets the global mask from data bit 2, shown on glob_mask and read back in bit 2. Data bits 0 and 1 give a one-cycle pulse on irq_rearm and fiq_rearm in the cycle after the write.
- R7: Address 0x010 bit 0 is the autoidle flag, read back in bit 0. Address 0x050 holds a 2-bit idle field in bits 1:0.
- R8: A write to 0x010 with data bit 1 set returns all state, including line configuration and the global bits, to the R1 values at that clock edge.
- R9: Line n's configuration is at 0x100 + 4*n, with route in bit 0 and priority in bits 7:2. It reads back in that layout and is exported on route_vec[n] and prio_vec[6n+5:6n].
- R10: Address 0x040 reads irq_code and address 0x044 reads fiq_code, zero-extended.
- R11: Writes to read-only and undecoded addresses change nothing. Undecoded reads return 0. Undecoded addresses include a bank or line index beyond the configured count and any address with nonzero low two bits.
- R12: pend_vec and mask_vec carry the raw pending and mask bits of every line, bank b at bits 32b+31:32b.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_lines | input | NUM_LINES | Raw level interrupt lines |
| wr_en | input | 1 | Write strobe for acc_addr / wr_data |
| acc_addr | input | ADDR_W | Byte address of the access |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Combinational read data for acc_addr |
| irq_code | input | CODE_W | Winning normal-route line from the arbiter |
| fiq_code | input | CODE_W | Winning fast-route line from the arbiter |
| pend_vec | output | NUM_LINES | Raw pending bits |
| mask_vec | output | NUM_LINES | Mask bits (1 = masked) |
| route_vec | output | NUM_LINES | Route bits (1 = fast) |
| prio_vec | output | NUM_LINES*PRIO_W | Packed per-line priorities |
| glob_mask | output | 1 | Global disable |
| irq_rearm | output | 1 | One-cycle re-arm pulse, normal route |
| fiq_rearm | output | 1 | One-cycle re-arm pulse, fast route |

## Verification
Random line patterns across both banks show whether rises only add to pending while any fall rebuilds the whole bank from inputs and software bits. Random mixes of mask loads, set and clear aliases and software set/clear writes, on top of randomly routed lines, show whether each alias touches only the bits named in its data and whether the two filtered views split pending by route. Directed writes to read-only, out-of-range and misaligned addresses are followed by full readback, which shows up any stray decode. A soft reset issued with all fields dirty shows whether every field returns to its reset value.

// File: rtl/intc_pkg.sv
package intc_pkg;

    localparam int LPB          = 32;     // lines per bank
    localparam int BANK_IDX_W   = 2;      // bank window holds up to 4 banks
    localparam int LINE_IDX_W   = 7;      // line window holds up to 128 lines
    localparam logic [31:0] REV_VALUE = 32'h0000_0021;

    localparam int A_REV      = 'h000;
    localparam int A_SYSCFG   = 'h010;
    localparam int A_STATUS   = 'h014;
    localparam int A_IRQ_CODE = 'h040;
    localparam int A_FIQ_CODE = 'h044;
    localparam int A_CTRL     = 'h048;
    localparam int A_IDLE     = 'h050;
    localparam int A_BANK     = 'h080;
    localparam int A_LINE     = 'h100;

    localparam logic [2:0] BR_INPUTS   = 3'd0;
    localparam logic [2:0] BR_MASK     = 3'd1;
    localparam logic [2:0] BR_MASK_CLR = 3'd2;
    localparam logic [2:0] BR_MASK_SET = 3'd3;
    localparam logic [2:0] BR_SW_SET   = 3'd4;
    localparam logic [2:0] BR_SW_CLR   = 3'd5;
    localparam logic [2:0] BR_PEND_N   = 3'd6;
    localparam logic [2:0] BR_PEND_F   = 3'd7;

    typedef enum logic [3:0] {
        SEL_NONE, SEL_REV, SEL_SYSCFG, SEL_STATUS, SEL_IRQ_CODE,
        SEL_FIQ_CODE, SEL_CTRL, SEL_IDLE, SEL_BANK, SEL_LINE
    } sel_e;

    typedef struct packed {
        logic [LPB-1:0] inp;
        logic [LPB-1:0] pend;
        logic [LPB-1:0] swi;
        logic [LPB-1:0] mask;
    } bank_state_t;

    localparam bank_state_t BANK_RST = '{inp: '0, pend: '0, swi: '0, mask: '1};

    typedef struct packed {
        logic       autoidle;
        logic [1:0] idle;
        logic       gmask;
        logic       irq_rearm;
        logic       fiq_rearm;
    } glob_t;

    localparam glob_t GLOB_RST = '0;

endpackage

// File: rtl/intc_addr_dec.sv
module intc_addr_dec
    import intc_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int NUM_BANKS = 2,
    parameter int NUM_LINES = NUM_BANKS * 32
) (
    input  logic [ADDR_W-1:0]     addr,
    output sel_e                  sel,
    output logic [BANK_IDX_W-1:0] bank,
    output logic [2:0]            breg,
    output logic [LINE_IDX_W-1:0] line
);

    localparam int BANK_END = A_BANK + NUM_BANKS * 'h20;
    localparam int LINE_END = A_LINE + NUM_LINES * 4;

    always_comb begin
        int a;
        a    = int'(addr);
        sel  = SEL_NONE;
        bank = addr[5 +: BANK_IDX_W];
        breg = addr[4:2];
        line = LINE_IDX_W'((a - A_LINE) >>> 2);
        if (addr[1:0] == 2'b00) begin
            if (a >= A_BANK && a < BANK_END) begin
                sel = SEL_BANK;
            end else if (a >= A_LINE && a < LINE_END) begin
                sel = SEL_LINE;
            end else begin
                case (a)
                    A_REV:      sel = SEL_REV;
                    A_SYSCFG:   sel = SEL_SYSCFG;
                    A_STATUS:   sel = SEL_STATUS;
                    A_IRQ_CODE: sel = SEL_IRQ_CODE;
                    A_FIQ_CODE: sel = SEL_FIQ_CODE;
                    A_CTRL:     sel = SEL_CTRL;
                    A_IDLE:     sel = SEL_IDLE;
                    default:    sel = SEL_NONE;
                endcase
            end
        end
    end

endmodule

// File: rtl/intc_bank.sv
module intc_bank
    import intc_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            soft_rst,
    input  logic [LPB-1:0]  lines,
    input  logic            wr_en,
    input  logic [2:0]      breg,
    input  logic [31:0]     wr_data,
    output bank_state_t     st
);

    bank_state_t st_d, st_q;

    always_comb begin
        logic [LPB-1:0] rise;
        logic [LPB-1:0] fall;
        st_d = st_q;
        rise = lines & ~st_q.inp;
        fall = ~lines & st_q.inp;
        // line events are applied first, register writes on top of them
        st_d.inp  = lines;
        st_d.pend = st_q.pend | rise;
        if (|fall) begin
            st_d.pend = lines | st_q.swi;
        end
        if (wr_en) begin
            case (breg)
                BR_MASK:     st_d.mask = wr_data;
                BR_MASK_CLR: st_d.mask = st_q.mask & ~wr_data;
                BR_MASK_SET: st_d.mask = st_q.mask | wr_data;
                BR_SW_SET: begin
                    st_d.swi  = st_q.swi | wr_data;
                    st_d.pend = st_d.pend | st_d.swi;
                end
                BR_SW_CLR: begin
                    st_d.swi  = st_q.swi & ~wr_data;
                    st_d.pend = st_d.swi & st_d.inp;
                end
                default: ;
            endcase
        end
        if (soft_rst) begin
            st_d = BANK_RST;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= BANK_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign st = st_q;

endmodule

// File: rtl/intc_line_cfg.sv
module intc_line_cfg
    import intc_pkg::*;
#(
    parameter int NUM_LINES = 64,
    parameter int PRIO_W    = 6
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        soft_rst,
    input  logic                        wr_en,
    input  logic [LINE_IDX_W-1:0]       line,
    input  logic [31:0]                 wr_data,
    output logic [NUM_LINES*PRIO_W-1:0] prio_vec,
    output logic [NUM_LINES-1:0]        route_vec
);

    typedef struct packed {
        logic [NUM_LINES*PRIO_W-1:0] prio;
        logic [NUM_LINES-1:0]        route;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        for (int i = 0; i < NUM_LINES; i++) begin
            if (wr_en && int'(line) == i) begin
                cfg_d.prio[i*PRIO_W +: PRIO_W] = wr_data[2 +: PRIO_W];
                cfg_d.route[i]                 = wr_data[0];
            end
        end
        if (soft_rst) begin
            cfg_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign prio_vec  = cfg_q.prio;
    assign route_vec = cfg_q.route;

endmodule

// File: rtl/intc_regfile.sv
module intc_regfile
    import intc_pkg::*;
#(
    parameter int NUM_BANKS = 2,
    parameter int NUM_LINES = NUM_BANKS * 32,
    parameter int ADDR_W    = 12,
    parameter int PRIO_W    = 6,
    parameter int CODE_W    = 7
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_LINES-1:0]        irq_lines,
    input  logic                        wr_en,
    input  logic [ADDR_W-1:0]           acc_addr,
    input  logic [31:0]                 wr_data,
    output logic [31:0]                 rd_data,
    input  logic [CODE_W-1:0]           irq_code,
    input  logic [CODE_W-1:0]           fiq_code,
    output logic [NUM_LINES-1:0]        pend_vec,
    output logic [NUM_LINES-1:0]        mask_vec,
    output logic [NUM_LINES-1:0]        route_vec,
    output logic [NUM_LINES*PRIO_W-1:0] prio_vec,
    output logic                        glob_mask,
    output logic                        irq_rearm,
    output logic                        fiq_rearm
);

    sel_e                  sel;
    logic [BANK_IDX_W-1:0] dec_bank;
    logic [2:0]            dec_breg;
    logic [LINE_IDX_W-1:0] dec_line;
    logic                  soft_rst;
    bank_state_t           bst [NUM_BANKS];
    glob_t                 g_d, g_q;

    intc_addr_dec #(
        .ADDR_W    (ADDR_W),
        .NUM_BANKS (NUM_BANKS),
        .NUM_LINES (NUM_LINES)
    ) u_dec (
        .addr (acc_addr),
        .sel  (sel),
        .bank (dec_bank),
        .breg (dec_breg),
        .line (dec_line)
    );

    assign soft_rst = wr_en && (sel == SEL_SYSCFG) && wr_data[1];

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic bank_wr;
        assign bank_wr = wr_en && (sel == SEL_BANK) && (int'(dec_bank) == b);

        intc_bank u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .soft_rst (soft_rst),
            .lines    (irq_lines[b*LPB +: LPB]),
            .wr_en    (bank_wr),
            .breg     (dec_breg),
            .wr_data  (wr_data),
            .st       (bst[b])
        );

        assign pend_vec[b*LPB +: LPB] = bst[b].pend;
        assign mask_vec[b*LPB +: LPB] = bst[b].mask;
    end

    intc_line_cfg #(
        .NUM_LINES (NUM_LINES),
        .PRIO_W    (PRIO_W)
    ) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .soft_rst  (soft_rst),
        .wr_en     (wr_en && (sel == SEL_LINE)),
        .line      (dec_line),
        .wr_data   (wr_data),
        .prio_vec  (prio_vec),
        .route_vec (route_vec)
    );

    // global state: next value
    always_comb begin
        g_d           = g_q;
        g_d.irq_rearm = 1'b0;
        g_d.fiq_rearm = 1'b0;
        if (wr_en) begin
            case (sel)
                SEL_SYSCFG: g_d.autoidle = wr_data[0];
                SEL_IDLE:   g_d.idle     = wr_data[1:0];
                SEL_CTRL: begin
                    g_d.gmask     = wr_data[2];
                    g_d.irq_rearm = wr_data[0];
                    g_d.fiq_rearm = wr_data[1];
                end
                default: ;
            endcase
        end
        if (soft_rst) begin
            g_d = GLOB_RST;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            g_q <= GLOB_RST;
        end else begin
            g_q <= g_d;
        end
    end

    assign glob_mask = g_q.gmask;
    assign irq_rearm = g_q.irq_rearm;
    assign fiq_rearm = g_q.fiq_rearm;

    // read mux
    always_comb begin
        rd_data = '0;
        case (sel)
            SEL_REV:      rd_data = REV_VALUE;
            SEL_SYSCFG:   rd_data[0] = g_q.autoidle;
            SEL_STATUS:   rd_data[0] = 1'b1;
            SEL_IRQ_CODE: rd_data = 32'(irq_code);
            SEL_FIQ_CODE: rd_data = 32'(fiq_code);
            SEL_CTRL:     rd_data[2] = g_q.gmask;
            SEL_IDLE:     rd_data[1:0] = g_q.idle;
            SEL_BANK: begin
                for (int b = 0; b < NUM_BANKS; b++) begin
                    if (int'(dec_bank) == b) begin
                        case (dec_breg)
                            BR_INPUTS: rd_data = bst[b].inp;
                            BR_MASK:   rd_data = bst[b].mask;
                            BR_SW_SET: rd_data = bst[b].swi;
                            BR_PEND_N: rd_data = bst[b].pend & ~bst[b].mask
                                                 & ~route_vec[b*LPB +: LPB];
                            BR_PEND_F: rd_data = bst[b].pend & ~bst[b].mask
                                                 & route_vec[b*LPB +: LPB];
                            default:   rd_data = '0;
                        endcase
                    end
                end
            end
            SEL_LINE: begin
                for (int i = 0; i < NUM_LINES; i++) begin
                    if (int'(dec_line) == i) begin
                        rd_data[2 +: PRIO_W] = prio_vec[i*PRIO_W +: PRIO_W];
                        rd_data[0]           = route_vec[i];
                    end
                end
            end
            default: rd_data = '0;
        endcase
    end

endmodule

// File: rtl/intc_regfile_chk.sv
module intc_regfile_chk #(
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] acc_addr,
    input logic [31:0]       wr_data,
    input logic [31:0]       rd_data,
    input logic              line0,
    input logic              pend0,
    input logic [31:0]       mask_lo,
    input logic              glob_mask,
    input logic              irq_rearm
);

    // R1
    rev_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(acc_addr) == 'h000) |-> (rd_data == 32'h21));

    // R1
    status_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(acc_addr) == 'h014) |-> (rd_data == 32'h1));

    // R11
    undecoded_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(acc_addr) == 'h004) |-> (rd_data == 32'h0));

    // R2
    line_rise_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && line0 && !$past(line0)) |=> pend0);

    // R3
    mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && int'(acc_addr) == 'h08C)
        |=> ((mask_lo & $past(wr_data)) == $past(wr_data)));

    // R6
    gmask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && int'(acc_addr) == 'h048) |=> (glob_mask == $past(wr_data[2])));

    // R6
    rearm_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && int'(acc_addr) == 'h048 && wr_data[0]) |=> irq_rearm);

endmodule

bind intc_regfile intc_regfile_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .acc_addr  (acc_addr),
    .wr_data   (wr_data),
    .rd_data   (rd_data),
    .line0     (irq_lines[0]),
    .pend0     (pend_vec[0]),
    .mask_lo   (mask_vec[31:0]),
    .glob_mask (glob_mask),
    .irq_rearm (irq_rearm)
);

// File: tb/intc_regfile_test.sv
module intc_regfile_test;

    localparam int NB = 2;
    localparam int NL = 64;
    localparam int AW = 12;
    localparam int PW = 6;
    localparam int CW = 7;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NL-1:0]   irq_lines = '0;
    logic            wr_en = 1'b0;
    logic [AW-1:0]   acc_addr = '0;
    logic [31:0]     wr_data = '0;
    logic [31:0]     rd_data;
    logic [CW-1:0]   irq_code = '0;
    logic [CW-1:0]   fiq_code = '0;
    logic [NL-1:0]   pend_vec, mask_vec, route_vec;
    logic [NL*PW-1:0] prio_vec;
    logic            glob_mask, irq_rearm, fiq_rearm;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [31:0] m_inp [NB];
    logic [31:0] m_pend[NB];
    logic [31:0] m_swi [NB];
    logic [31:0] m_mask[NB];
    logic [NL-1:0]    m_route;
    logic [NL*PW-1:0] m_prio;

    always #5 clk = ~clk;

    intc_regfile #(.NUM_BANKS(NB), .NUM_LINES(NL), .ADDR_W(AW), .PRIO_W(PW), .CODE_W(CW)) uut (
        .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .wr_en(wr_en),
        .acc_addr(acc_addr), .wr_data(wr_data), .rd_data(rd_data),
        .irq_code(irq_code), .fiq_code(fiq_code), .pend_vec(pend_vec),
        .mask_vec(mask_vec), .route_vec(route_vec), .prio_vec(prio_vec),
        .glob_mask(glob_mask), .irq_rearm(irq_rearm), .fiq_rearm(fiq_rearm)
    );

    function automatic logic [AW-1:0] bank_addr(input int b, input int r);
        return AW'('h080 + b * 'h20 + r * 4);
    endfunction

    function automatic logic [31:0] exp_pend_view(input int b, input bit fast);
        logic [31:0] rt;
        rt = m_route[b*32 +: 32];
        return m_pend[b] & ~m_mask[b] & (fast ? rt : ~rt);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int b = 0; b < NB; b++) begin
            m_inp[b] = '0; m_pend[b] = '0; m_swi[b] = '0; m_mask[b] = '1;
        end
        m_route = '0;
        m_prio  = '0;
    endtask

    task automatic model_lines(input logic [NL-1:0] v);
        for (int b = 0; b < NB; b++) begin
            logic [31:0] nv, rise, fall;
            nv   = v[b*32 +: 32];
            rise = nv & ~m_inp[b];
            fall = ~nv & m_inp[b];
            m_inp[b] = nv;
            if (|fall) m_pend[b] = nv | m_swi[b];
            else       m_pend[b] = m_pend[b] | rise;
        end
    endtask

    task automatic model_bank_wr(input int b, input int r, input logic [31:0] d);
        case (r)
            1: m_mask[b] = d;
            2: m_mask[b] = m_mask[b] & ~d;
            3: m_mask[b] = m_mask[b] | d;
            4: begin m_swi[b] = m_swi[b] | d; m_pend[b] = m_pend[b] | m_swi[b]; end
            5: begin m_swi[b] = m_swi[b] & ~d; m_pend[b] = m_swi[b] & m_inp[b]; end
            default: ;
        endcase
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; acc_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
        acc_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic set_lines(input logic [NL-1:0] v);
        @(negedge clk);
        irq_lines = v;
        @(negedge clk);
        model_lines(v);
    endtask

    task automatic verify_banks(input string tag);
        logic [31:0] d;
        for (int b = 0; b < NB; b++) begin
            rd(bank_addr(b, 0), d); chk({tag, " R4 inputs"}, d, m_inp[b]);
            rd(bank_addr(b, 1), d); chk({tag, " R3 mask"}, d, m_mask[b]);
            rd(bank_addr(b, 4), d); chk({tag, " R4 swi"}, d, m_swi[b]);
            rd(bank_addr(b, 6), d); chk({tag, " R5 pend normal"}, d, exp_pend_view(b, 1'b0));
            rd(bank_addr(b, 7), d); chk({tag, " R5 pend fast"}, d, exp_pend_view(b, 1'b1));
            chk({tag, " R12 pend_vec"}, pend_vec[b*32 +: 32], m_pend[b]);
            chk({tag, " R12 mask_vec"}, mask_vec[b*32 +: 32], m_mask[b]);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'd20240611));
        model_reset();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(12'h000, d); chk("R1 revision", d, 32'h21);
        rd(12'h014, d); chk("R1 status", d, 32'h1);
        rd(12'h048, d); chk("R1 control", d, 32'h0);
        rd(12'h010, d); chk("R1 sysconfig", d, 32'h0);
        chk("R1 glob_mask", {31'b0, glob_mask}, 32'h0);
        chk("R1 prio_vec", 32'(|prio_vec), 32'h0);
        verify_banks("reset");

        // R10 winner codes
        irq_code = 7'h2a; fiq_code = 7'h55;
        rd(12'h040, d); chk("R10 irq code", d, 32'h2a);
        rd(12'h044, d); chk("R10 fiq code", d, 32'h55);

        // R9 line configuration
        wr(12'h114, 32'h0000_00F5);
        m_prio[5*PW +: PW] = 6'h3d; m_route[5] = 1'b1;
        rd(12'h114, d); chk("R9 line5 readback", d, 32'hF5);
        chk("R9 line5 prio_vec", 32'(prio_vec[5*PW +: PW]), 32'h3d);
        chk("R9 line5 route_vec", 32'(route_vec[5]), 32'h1);
        for (int i = 0; i < NL; i++) begin
            logic [31:0] v;
            v = $urandom;
            wr(AW'('h100 + 4 * i), v);
            m_prio[i*PW +: PW] = v[7:2];
            m_route[i] = v[0];
            rd(AW'('h100 + 4 * i), d);
            chk("R9 line readback", d, {24'b0, v[7:2], 1'b0, v[0]});
        end
        chk("R9 route_vec lo", route_vec[31:0], m_route[31:0]);
        chk("R9 route_vec hi", route_vec[63:32], m_route[63:32]);
        chk("R9 prio_vec part", prio_vec[31:0], m_prio[31:0]);

        // R6 control
        wr(12'h048, 32'h4);
        chk("R6 glob_mask set", 32'(glob_mask), 32'h1);
        chk("R6 no rearm", {30'b0, irq_rearm, fiq_rearm}, 32'h0);
        rd(12'h048, d); chk("R6 ctrl readback", d, 32'h4);
        wr(12'h048, 32'h3);
        chk("R6 glob_mask clear", 32'(glob_mask), 32'h0);
        chk("R6 both rearm pulse", {30'b0, irq_rearm, fiq_rearm}, 32'h3);
        @(negedge clk);
        chk("R6 rearm one cycle", {30'b0, irq_rearm, fiq_rearm}, 32'h0);
        wr(12'h048, 32'h2);
        chk("R6 fast rearm only", {30'b0, irq_rearm, fiq_rearm}, 32'h1);

        // R7 autoidle and idle
        wr(12'h010, 32'h1);
        rd(12'h010, d); chk("R7 autoidle", d, 32'h1);
        wr(12'h050, 32'h3);
        rd(12'h050, d); chk("R7 idle", d, 32'h3);
        wr(12'h050, 32'hFFFF_FFFC);
        rd(12'h050, d); chk("R7 idle field only", d, 32'h0);

        // R11 ignored writes and undecoded reads
        wr(12'h000, 32'h0);
        rd(12'h000, d); chk("R11 revision read-only", d, 32'h21);
        wr(12'h014, 32'h0);
        rd(12'h014, d); chk("R11 status read-only", d, 32'h1);
        wr(12'h0C4, 32'h0);
        rd(12'h0C4, d); chk("R11 bank beyond count", d, 32'h0);
        wr(bank_addr(0, 6), 32'hFFFF_FFFF);
        wr(bank_addr(1, 7), 32'hFFFF_FFFF);
        wr(bank_addr(0, 0), 32'hFFFF_FFFF);
        wr(12'h085, 32'h0);
        wr(12'h200, 32'hFF);
        rd(12'h200, d); chk("R11 line beyond count", d, 32'h0);
        rd(12'h116, d); chk("R11 misaligned read", d, 32'h0);
        rd(12'h0FC, d); chk("R11 gap read", d, 32'h0);
        chk("R11 prio unchanged", prio_vec[31:0], m_prio[31:0]);
        verify_banks("R11");

        // R3 mask aliases
        wr(bank_addr(0, 2), 32'h0000_FF0F);
        model_bank_wr(0, 2, 32'h0000_FF0F);
        rd(bank_addr(0, 2), d); chk("R3 clear alias reads 0", d, 32'h0);
        wr(bank_addr(0, 3), 32'h0000_0F00);
        model_bank_wr(0, 3, 32'h0000_0F00);
        rd(bank_addr(0, 3), d); chk("R3 set alias reads 0", d, 32'h0);
        verify_banks("R3");

        // R2 line edges
        set_lines(64'h0000_0000_0000_0009);
        verify_banks("R2 rise");
        set_lines(64'h0000_0000_0000_0001);
        verify_banks("R2 fall");

        // R4 software set and clear
        wr(bank_addr(1, 4), 32'h8000_0011);
        model_bank_wr(1, 4, 32'h8000_0011);
        verify_banks("R4 set");
        wr(bank_addr(1, 5), 32'h0000_0010);
        model_bank_wr(1, 5, 32'h0000_0010);
        rd(bank_addr(1, 5), d); chk("R4 sw clear reads 0", d, 32'h0);
        verify_banks("R4 clear");

        // random mix
        for (int it = 0; it < 300; it++) begin
            int op;
            op = $urandom_range(0, 3);
            if (op == 0) begin
                set_lines({$urandom, $urandom} & {$urandom, $urandom});
            end else begin
                int b, r;
                logic [31:0] v;
                b = $urandom_range(0, NB - 1);
                r = $urandom_range(0, 7);
                v = $urandom & $urandom;
                wr(bank_addr(b, r), v);
                model_bank_wr(b, r, v);
            end
            verify_banks("random");
        end

        // R8 soft reset
        set_lines('0);
        wr(12'h010, 32'h1);
        wr(12'h048, 32'h4);
        wr(12'h050, 32'h2);
        wr(bank_addr(0, 4), 32'h00F0_0000);
        model_bank_wr(0, 4, 32'h00F0_0000);
        wr(12'h010, 32'h2);
        model_reset();
        verify_banks("R8");
        rd(12'h010, d); chk("R8 autoidle cleared", d, 32'h0);
        rd(12'h050, d); chk("R8 idle cleared", d, 32'h0);
        chk("R8 glob_mask cleared", 32'(glob_mask), 32'h0);
        chk("R8 route cleared", 32'(|route_vec), 32'h0);
        chk("R8 prio cleared", 32'(|prio_vec), 32'h0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule